// File: doc/BRIEF.md
# Token-Chained Serial Readout Controller

This block is the digital controller that sits in each front-end chip of a chain of chips sharing one serial data line. Each chip runs a power-pulsed cycle: it wakes for acquisition and records incoming event words into a small local store. It then waits through conversion until a readout token arrives. After readout it drops back into a powered-down idle state until the next acquisition starts.

Readout is passed from chip to chip along the chain. A chip that receives the token and holds stored events drives one frame onto the shared line, most significant bit first, one bit per clock. The frame carries the chip identifier, then the event count, then the event words in the order they arrived. The chip then emits a one-clock token pulse for its neighbour. A chip with nothing stored forwards the token on the next clock and never drives the line, so a long chain of mostly empty chips is crossed quickly. The power-enable output frames the whole active part of the cycle and lets the analog and digital sections be shut down for the rest of the cycle.

Top module: `ring_readout_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after it, pwr_en, tx_on, ro_end and ser_out are all 0.
- R2: An acq_start pulse in the powered-down state raises pwr_en on the next clock; pwr_en stays 1 through acquisition, the wait for the token and the whole frame.
- R3: An event word is stored only when hit_valid is high in the acquisition phase (after acq_start, before conv_start); hit_valid at any other time leaves the stored events, and so the transmitted frame, unchanged.
- R4: The store holds at most DEPTH (default 4) words; later hits in the same acquisition are dropped and the count field reports DEPTH.
- R5: ro_start is ignored while powered down and during acquisition: neither tx_on nor ro_end is raised in response.
- R6: When the token arrives and no events are stored, ro_end is 1 for exactly the next clock, tx_on stays 0, and pwr_en drops in that same clock.
- R7: When the token arrives with N > 0 events stored, the frame starts on the next clock: first the 8-bit chip_id, then the 8-bit count N, then N 16-bit words in arrival order, every field most significant bit first, one bit per clock.
- R8: tx_on is 1 for exactly the 16 + 16*N clocks of the frame and 0 at every other time.
- R9: In the clock after the last frame bit, tx_on is 0, ro_end is 1 for that one clock only, and pwr_en is 0.
- R10: ser_out is 0 whenever tx_on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_id | input | 8 | Identifier placed at the head of this chip's frame |
| acq_start | input | 1 | Pulse that wakes the chip and opens acquisition |
| conv_start | input | 1 | Pulse that closes acquisition and begins the conversion/token wait |
| hit_valid | input | 1 | Event word present on hit_word |
| hit_word | input | 16 | Event word from the front end |
| ro_start | input | 1 | Readout token from the previous chip |
| ser_out | output | 1 | Serial data to the shared line |
| tx_on | output | 1 | Enables this chip's line driver |
| ro_end | output | 1 | One-clock token pulse to the next chip |
| pwr_en | output | 1 | Power enable for the analog and digital sections |

## Verification
Every response here lags its cause by exactly one clock: pwr_en after acq_start, the first frame bit and tx_on after ro_start, and ro_end after either the token (empty store) or the last frame bit. The bench drives inputs just after a rising edge and samples outputs one time unit after the following rising edge, so each check sees the single register stage settled. Frame bits are compared one per clock against a frame that the bench assembles from the identifier and the words it sent. The end-of-frame check sits exactly 16 + 16*N clocks after the token edge.

// File: rtl/rro_pkg.sv
// Package rro_pkg
// Shared types for the token-chained readout controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rro_pkg;

    // Phases of the power-pulsed cycle.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,   // powered down, waiting for acq_start
        PH_ACQ  = 2'd1,   // recording event words
        PH_CONV = 2'd2,   // conversion done or running, waiting for token
        PH_SEND = 2'd3    // shifting the frame onto the shared line
    } rro_phase_t;

endpackage

// File: rtl/rro_event_store.sv
// Module rro_event_store
// Small register store for event words captured during acquisition.
// Words are kept in arrival order; writes beyond DEPTH are dropped.
// Assumes: clr and wr_en are never asserted together by the sequencer;
// CNT_W is wide enough to hold DEPTH.
module rro_event_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] slot [DEPTH];
    logic              has_room;

    assign has_room = (count < CNT_W'(DEPTH));

    // Track the number of stored words, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (wr_en && has_room) begin
            count <= count + 1'b1;
        end
    end

    // One register per slot; a slot is written when it is the next free one.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && has_room && (count == CNT_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    // Read port: the sequencer picks the word to serialise.
    always_comb begin
        rd_data = slot[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot[i];
        end
    end

endmodule

// File: rtl/rro_serializer.sv
// Module rro_serializer
// Parallel-load, MSB-first shift register feeding the serial line.
// Assumes: a load takes priority over a shift in the same clock.
module rro_serializer #(
    parameter int SH_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SH_W-1:0] load_data,
    input  logic            shift,
    output logic            msb
);

    logic [SH_W-1:0] sr;

    // Load a new segment or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_data;
        end else if (shift) begin
            sr <= sr << 1;
        end
    end

    assign msb = sr[SH_W-1];

endmodule

// File: rtl/rro_sequencer.sv
// Module rro_sequencer
// Phase machine for one chip: power envelope, acquisition window,
// token handling and frame segmentation (header, then each word).
// Assumes: the header is HDR_W bits and each word WORD_W bits; the
// serializer is loaded in the same clock as a segment starts.
module rro_sequencer
    import rro_pkg::*;
#(
    parameter int HDR_W  = 16,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 8,
    localparam int SH_W  = (HDR_W > WORD_W) ? HDR_W : WORD_W,
    localparam int BL_W  = $clog2(SH_W + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_start,
    input  logic             conv_start,
    input  logic             ro_start,
    input  logic [CNT_W-1:0] ev_count,
    output logic             store_clr,
    output logic             store_wr_ok,
    output logic             load_hdr,
    output logic             load_word,
    output logic             shift,
    output logic [IDX_W-1:0] rd_idx,
    output logic             tx_on,
    output logic             ro_end,
    output logic             pwr_en
);

    rro_phase_t       phase;
    logic [BL_W-1:0]  bits_left;
    logic [CNT_W-1:0] word_idx;
    logic             seg_last;
    logic             more_words;
    logic             token_empty;
    logic             token_data;

    assign seg_last    = (bits_left == BL_W'(1));
    assign more_words  = (word_idx < ev_count);
    assign token_empty = (phase == PH_CONV) && ro_start && (ev_count == '0);
    assign token_data  = (phase == PH_CONV) && ro_start && (ev_count != '0);

    // Control strobes toward the store and the serializer.
    always_comb begin
        store_clr   = (phase == PH_OFF) && acq_start;
        store_wr_ok = (phase == PH_ACQ);
        load_hdr    = token_data;
        load_word   = (phase == PH_SEND) && seg_last && more_words;
        shift       = (phase == PH_SEND) && !seg_last;
        rd_idx      = word_idx[IDX_W-1:0];
    end

    // Phase transitions of the power-pulsed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF:  if (acq_start)  phase <= PH_ACQ;
                PH_ACQ:  if (conv_start) phase <= PH_CONV;
                PH_CONV: begin
                    if (token_empty)     phase <= PH_OFF;
                    else if (token_data) phase <= PH_SEND;
                end
                PH_SEND: if (seg_last && !more_words) phase <= PH_OFF;
                default: phase <= PH_OFF;
            endcase
        end
    end

    // Bit count of the current segment and index of the next word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
            word_idx  <= '0;
        end else if (load_hdr) begin
            bits_left <= BL_W'(HDR_W);
            word_idx  <= '0;
        end else if (load_word) begin
            bits_left <= BL_W'(WORD_W);
            word_idx  <= word_idx + 1'b1;
        end else if (shift) begin
            bits_left <= bits_left - 1'b1;
        end
    end

    // Token output: one clock after an empty token or after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ro_end <= 1'b0;
        end else begin
            ro_end <= token_empty ||
                      ((phase == PH_SEND) && seg_last && !more_words);
        end
    end

    assign tx_on  = (phase == PH_SEND);
    assign pwr_en = (phase != PH_OFF);

endmodule

// File: rtl/ring_readout_ctrl.sv
// Module ring_readout_ctrl
// Per-chip controller of a token-chained readout: captures event words,
// waits for the token, sends {chip_id, count, words} MSB first on the
// shared line, then passes the token on. Empty chips forward at once.
// Assumes: the count field is CNT_W bits and DEPTH fits in it.
module ring_readout_ctrl #(
    parameter int ID_W   = 8,
    parameter int CNT_W  = 8,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   chip_id,
    input  logic              acq_start,
    input  logic              conv_start,
    input  logic              hit_valid,
    input  logic [WORD_W-1:0] hit_word,
    input  logic              ro_start,
    output logic              ser_out,
    output logic              tx_on,
    output logic              ro_end,
    output logic              pwr_en
);

    localparam int HDR_W = ID_W + CNT_W;
    localparam int SH_W  = (HDR_W > WORD_W) ? HDR_W : WORD_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              store_clr;
    logic              store_wr_ok;
    logic              load_hdr;
    logic              load_word;
    logic              shift;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  ev_count;
    logic [WORD_W-1:0] rd_word;
    logic [SH_W-1:0]   seg_data;
    logic              sh_msb;

    rro_sequencer #(
        .HDR_W (HDR_W),
        .WORD_W(WORD_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq_start),
        .conv_start (conv_start),
        .ro_start   (ro_start),
        .ev_count   (ev_count),
        .store_clr  (store_clr),
        .store_wr_ok(store_wr_ok),
        .load_hdr   (load_hdr),
        .load_word  (load_word),
        .shift      (shift),
        .rd_idx     (rd_idx),
        .tx_on      (tx_on),
        .ro_end     (ro_end),
        .pwr_en     (pwr_en)
    );

    rro_event_store #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (store_clr),
        .wr_en  (hit_valid && store_wr_ok),
        .wr_data(hit_word),
        .rd_idx (rd_idx),
        .count  (ev_count),
        .rd_data(rd_word)
    );

    // Left-align the next segment in the shift register.
    always_comb begin
        if (load_hdr) seg_data = SH_W'({chip_id, ev_count}) << (SH_W - HDR_W);
        else          seg_data = SH_W'(rd_word) << (SH_W - WORD_W);
    end

    rro_serializer #(
        .SH_W(SH_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_hdr || load_word),
        .load_data(seg_data),
        .shift    (shift),
        .msb      (sh_msb)
    );

    assign ser_out = tx_on & sh_msb;

endmodule

// File: rtl/rro_checker.sv
// Module rro_checker
// Port-level protocol properties of ring_readout_ctrl, bound to the top.
// Assumes: observes the top-level ports only.
module rro_checker (
    input logic clk,
    input logic rst_n,
    input logic ro_start,
    input logic ser_out,
    input logic tx_on,
    input logic ro_end,
    input logic pwr_en
);

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> !ser_out);                               // R10

    AST_TOKEN_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ro_end |=> !ro_end);                                // R9

    AST_TOKEN_NOT_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ro_end |-> !tx_on);                                 // R9

    AST_SEND_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on |-> pwr_en);                                  // R2

    AST_SEND_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> $past(ro_start));                  // R7

    AST_OFF_IGNORES_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && ro_start) |=> (!tx_on && !ro_end));     // R5

    AST_POWER_DOWN_WITH_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> ro_end);                          // R6

endmodule

bind ring_readout_ctrl rro_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ro_start(ro_start),
    .ser_out (ser_out),
    .tx_on   (tx_on),
    .ro_end  (ro_end),
    .pwr_en  (pwr_en)
);

// File: tb/sim_ring_readout_ctrl.sv
// Bench sim_ring_readout_ctrl
// Directed scenarios, one task each; inputs change 1 time unit after a
// rising edge and outputs are sampled 1 time unit after a rising edge.
module sim_ring_readout_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  chip_id = 8'h00;
    logic        acq_start = 1'b0;
    logic        conv_start = 1'b0;
    logic        hit_valid = 1'b0;
    logic [15:0] hit_word = 16'h0000;
    logic        ro_start = 1'b0;
    logic        ser_out;
    logic        tx_on;
    logic        ro_end;
    logic        pwr_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [15:0] exp_w [4];
    int n_exp = 0;

    ring_readout_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .chip_id(chip_id),
        .acq_start(acq_start), .conv_start(conv_start),
        .hit_valid(hit_valid), .hit_word(hit_word),
        .ro_start(ro_start), .ser_out(ser_out), .tx_on(tx_on),
        .ro_end(ro_end), .pwr_en(pwr_en)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
            report();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Acquisition: wake, record words, close with conv_start.
    task automatic acquire(input int nw, input logic [15:0] base);
        acq_start = 1'b1;
        tick();
        acq_start = 1'b0;
        check(pwr_en == 1'b1, "R2 pwr_en after acq_start", pwr_en, 1);
        for (int k = 0; k < nw; k++) begin
            hit_valid = 1'b1;
            hit_word  = base + 16'(k * 16'h1111);
            if (n_exp < 4) begin
                exp_w[n_exp] = hit_word;
                n_exp++;
            end
            tick();
        end
        hit_valid = 1'b0;
        conv_start = 1'b1;
        tick();
        conv_start = 1'b0;
        check(pwr_en == 1'b1 && tx_on == 1'b0, "R2 pwr_en held awaiting token",
              {pwr_en, tx_on}, 2'b10);
    endtask

    // Token in, then compare the frame bit by bit and the token out.
    task automatic readout(input string req);
        logic [79:0] frame;
        int len;
        int bad_bits;
        frame = 80'(chip_id);
        frame = (frame << 8) | 80'(n_exp);
        for (int k = 0; k < n_exp; k++) frame = (frame << 16) | 80'(exp_w[k]);
        len = 16 + 16 * n_exp;
        ro_start = 1'b1;
        tick();
        ro_start = 1'b0;
        bad_bits = 0;
        for (int i = 0; i < len; i++) begin
            if (tx_on !== 1'b1) begin
                bad_bits++;
                $display("FAIL R8 %s: tx_on at bit %0d act=%b exp=1", req, i, tx_on);
            end
            if (ser_out !== frame[len-1-i]) begin
                bad_bits++;
                $display("FAIL R7 %s: bit %0d act=%b exp=%b", req, i, ser_out,
                         frame[len-1-i]);
            end
            tick();
        end
        n_chk++;
        if (bad_bits != 0) n_bad++;
        check(tx_on == 1'b0 && ro_end == 1'b1 && pwr_en == 1'b0,
              "R9 token out after last bit", {tx_on, ro_end, pwr_en}, 3'b010);
        check(ser_out == 1'b0, "R10 line quiet after frame", ser_out, 0);
        tick();
        check(ro_end == 1'b0, "R9 ro_end one clock", ro_end, 0);
        n_exp = 0;
    endtask

    task automatic t_reset();
        tick();
        check({pwr_en, tx_on, ro_end, ser_out} == 4'b0, "R1 outputs in reset",
              {pwr_en, tx_on, ro_end, ser_out}, 0);
        rst_n = 1'b1;
        tick();
        check({pwr_en, tx_on, ro_end, ser_out} == 4'b0, "R1 outputs after reset",
              {pwr_en, tx_on, ro_end, ser_out}, 0);
    endtask

    task automatic t_normal();
        chip_id = 8'hA5;
        acquire(3, 16'h8001);
        readout("R7 three words");
    endtask

    task automatic t_empty();
        chip_id = 8'h3C;
        acquire(0, 16'h0);
        ro_start = 1'b1;
        tick();
        ro_start = 1'b0;
        check(ro_end == 1'b1 && tx_on == 1'b0 && pwr_en == 1'b0,
              "R6 empty chip forwards token", {ro_end, tx_on, pwr_en}, 3'b100);
        tick();
        check(ro_end == 1'b0 && tx_on == 1'b0, "R6 token pulse ends",
              {ro_end, tx_on}, 0);
    endtask

    task automatic t_overflow();
        chip_id = 8'h01;
        acquire(6, 16'h1234);
        readout("R4 saturated store");
    endtask

    task automatic t_ignored();
        chip_id = 8'hF0;
        hit_valid = 1'b1;
        hit_word = 16'hDEAD;
        ro_start = 1'b1;
        tick();
        hit_valid = 1'b0;
        ro_start = 1'b0;
        check(tx_on == 1'b0 && ro_end == 1'b0 && pwr_en == 1'b0,
              "R5 token ignored while off", {tx_on, ro_end, pwr_en}, 0);
        acq_start = 1'b1;
        tick();
        acq_start = 1'b0;
        hit_valid = 1'b1;
        hit_word = 16'h0F0F;
        exp_w[0] = 16'h0F0F;
        n_exp = 1;
        ro_start = 1'b1;
        tick();
        hit_valid = 1'b0;
        ro_start = 1'b0;
        check(tx_on == 1'b0 && ro_end == 1'b0, "R5 token ignored in acquisition",
              {tx_on, ro_end}, 0);
        tick();
        check(tx_on == 1'b0 && ro_end == 1'b0, "R5 no late response",
              {tx_on, ro_end}, 0);
        conv_start = 1'b1;
        tick();
        conv_start = 1'b0;
        hit_valid = 1'b1;
        hit_word = 16'hBEEF;
        tick();
        hit_valid = 1'b0;
        readout("R3 hits outside acquisition dropped");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_empty();
        t_overflow();
        t_ignored();
        t_normal();
        report();
    end

endmodule